// File: doc/BRIEF.md
# Interrupt Pending and Dispatch Core

This block gathers a bank of interrupt request lines, keeps for each one a pending bit, an in-service bit and a mask bit, and forwards the chosen request to one of a set of upstream interrupt lines. Each input is separately configured as edge or level sensitive. An edge input latches a pending request when it rises and holds it until software clears it. A level input's pending bit simply mirrors the line. Each input carries an 8-bit vector that names the upstream line it drives.

Each clock cycle the core runs at most one raise evaluation and one lower evaluation. A raise picks the lowest-numbered input that has a raise event, is pending and is unmasked, marks it in service and drives its vector's upstream line high. A lower picks the lowest-numbered input that has a lower event, is in service and is no longer pending, takes it out of service and drives its vector's line low. Raise events come from rising inputs and from unmasking. Lower events come from falling inputs, from newly set mask bits and from clear writes. A register front-end, with whole-word writes and no byte merging, delivers mask, edge-select, clear, vector, polarity and route writes. Reads are combinational.

Top module: `pic_dispatch_core`

## Requirements
- R1: After reset every mask bit is one. Edge select, pending, in-service, polarity, vector and route entries are zero, and every upstream output is low.
- R2: An edge-mode input (edge-select bit = 1) becomes pending only when it is high and its last sampled level was low. A falling edge-mode input leaves its pending bit set.
- R3: A level-mode input (edge-select bit = 0) has a pending bit that follows the input line every cycle.
- R4: On a raise evaluation the lowest-index input with a raise event, pending set and mask clear is placed in service, and the output named by its vector is high from the next cycle. Other candidates are left pending in that cycle.
- R5: On a lower evaluation the lowest-index input with a lower event, in service and not pending is taken out of service, and the output named by its vector is low from the next cycle.
- R6: A clear write (select code 2) acts only on edge-mode bits of the data word. It clears their pending bits, runs a lower evaluation over them and removes them all from service. Level-mode bits in the data have no effect.
- R7: A mask write (select code 0) loads the mask. Bits set in the old mask and clear in the data run a raise evaluation. Bits clear in the old mask and set in the data run a lower evaluation.
- R8: Reading select code 6 returns the in-service bits AND NOT the mask. Reading select code 0 returns the mask.
- R9: The polarity word (select code 4) and the per-input route entries (select code 5, entry chosen by the index) are stored and read back, and have no effect on dispatch.
- R10: A vector value equal to or above the number of outputs drives no output, but the input still enters and leaves service.
- R11: When a lower and a raise in the same cycle name the same output, the lower is applied first and the raise wins, so the output ends high.
- R12: Select codes: 0 mask, 1 edge select, 2 clear, 3 vector, 4 polarity, 5 route, 6 status. A vector write (code 3) stores data bits [7:0] into the entry given by the index, and a read of code 3 returns that entry zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irqIn | input | 64 | Interrupt request lines |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 3 | Write register select code |
| cfgIdx | input | 6 | Entry index for vector and route writes |
| cfgData | input | 64 | Write data word |
| rdSel | input | 3 | Read register select code |
| rdIdx | input | 6 | Entry index for vector and route reads |
| rdData | output | 64 | Combinational read data |
| irqOut | output | 64 | Upstream interrupt lines |

## Verification
A clear write that takes one edge input out of service can fall in the same cycle as a new edge input rising, so that a lower and a raise are evaluated together. The bench gives both inputs the same vector, drives the clear and the rising line in one cycle, and expects the shared output to stay high while the status word shows only the newly raised input in service. A second overlap, a mode change followed by a mask write that lowers an in-service input whose pending bit went away, is judged by the output and by the status read after unmasking.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [2:0] {
    SEL_MASK   = 3'd0,
    SEL_EDGE   = 3'd1,
    SEL_CLEAR  = 3'd2,
    SEL_VECTOR = 3'd3,
    SEL_POL    = 3'd4,
    SEL_ROUTE  = 3'd5,
    SEL_STATUS = 3'd6
  } regsel_e;

  typedef struct packed {
    logic maskWr;
    logic edgeWr;
    logic clrWr;
    logic vecWr;
    logic polWr;
    logic routeWr;
  } strobe_t;

endpackage

// File: rtl/pic_lowest.sv
module pic_lowest #(
  parameter int N = 64
) (
  input  logic [N-1:0]         req,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  assign found = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_IN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgSel,
  output strobe_t           stb,
  output logic [NUM_IN-1:0] riseEv,
  output logic [NUM_IN-1:0] fallEv
);
  logic [NUM_IN-1:0] lastLevel;

  always_ff @(posedge clk) begin
    if (rst) lastLevel <= '0;
    else     lastLevel <= irqIn;
  end

  assign riseEv = irqIn & ~lastLevel;
  assign fallEv = ~irqIn & lastLevel;

  always_comb begin
    stb = '0;
    if (cfgWrEn) begin
      case (regsel_e'(cfgSel))
        SEL_MASK:   stb.maskWr  = 1'b1;
        SEL_EDGE:   stb.edgeWr  = 1'b1;
        SEL_CLEAR:  stb.clrWr   = 1'b1;
        SEL_VECTOR: stb.vecWr   = 1'b1;
        SEL_POL:    stb.polWr   = 1'b1;
        SEL_ROUTE:  stb.routeWr = 1'b1;
        default:    stb = '0;
      endcase
    end
  end

  a_r12_single_strobe: assert property (@(posedge clk) disable iff (rst)
    !cfgWrEn |-> (stb == '0));
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_IN  = 64,
  parameter int NUM_OUT = 64,
  parameter int VEC_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  strobe_t                   stb,
  input  logic [NUM_IN-1:0]         irqIn,
  input  logic [NUM_IN-1:0]         riseEv,
  input  logic [NUM_IN-1:0]         fallEv,
  input  logic [$clog2(NUM_IN)-1:0] cfgIdx,
  input  logic [NUM_IN-1:0]         cfgData,
  input  logic [2:0]                rdSel,
  input  logic [$clog2(NUM_IN)-1:0] rdIdx,
  output logic [NUM_IN-1:0]         rdData,
  output logic [NUM_OUT-1:0]        irqOut
);
  localparam int IW = $clog2(NUM_IN);
  localparam int OW = $clog2(NUM_OUT);
  localparam logic [VEC_W:0] OUT_LIM = NUM_OUT[VEC_W:0];

  logic [NUM_IN-1:0] pending, inService, intMask, edgeSel, polReg;
  logic [VEC_W-1:0]  vecTab   [NUM_IN];
  logic [VEC_W-1:0]  routeTab [NUM_IN];

  logic [NUM_IN-1:0] clrBits, unmaskBits, newMaskBits, maskNext, pendNext;
  logic [NUM_IN-1:0] riseSet, fallSet, riseHot, fallHot, isrNext;
  logic              riseFound, fallFound, riseOk, fallOk;
  logic [IW-1:0]     riseIdx, fallIdx;
  logic [VEC_W-1:0]  riseVec, fallVec;
  logic [NUM_OUT-1:0] outNext;
  logic              armed;

  assign clrBits     = stb.clrWr  ? (cfgData & edgeSel) : '0;
  assign unmaskBits  = stb.maskWr ? (intMask & ~cfgData) : '0;
  assign newMaskBits = stb.maskWr ? (~intMask & cfgData) : '0;
  assign maskNext    = stb.maskWr ? cfgData : intMask;

  // Pending update: edge bits latch rises, level bits mirror the line.
  for (genvar g = 0; g < NUM_IN; g++) begin : g_pend
    assign pendNext[g] = edgeSel[g] ? ((pending[g] | riseEv[g]) & ~clrBits[g])
                                    : irqIn[g];
  end

  assign riseSet = (riseEv | unmaskBits) & pendNext & ~maskNext;
  assign fallSet = (fallEv | newMaskBits | clrBits) & inService & ~pendNext;

  pic_lowest #(.N(NUM_IN)) u_risePick (.req(riseSet), .found(riseFound), .idx(riseIdx));
  pic_lowest #(.N(NUM_IN)) u_fallPick (.req(fallSet), .found(fallFound), .idx(fallIdx));

  assign riseHot = {{(NUM_IN-1){1'b0}}, riseFound} << riseIdx;
  assign fallHot = {{(NUM_IN-1){1'b0}}, fallFound} << fallIdx;
  assign isrNext = (inService | riseHot) & ~fallHot & ~clrBits;

  assign riseVec = vecTab[riseIdx];
  assign fallVec = vecTab[fallIdx];
  assign riseOk  = riseFound && ({1'b0, riseVec} < OUT_LIM);
  assign fallOk  = fallFound && ({1'b0, fallVec} < OUT_LIM);

  // Lower first, then raise: a raise on the same output wins.
  always_comb begin
    outNext = irqOut;
    if (fallOk) outNext[fallVec[OW-1:0]] = 1'b0;
    if (riseOk) outNext[riseVec[OW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= '0;
      inService <= '0;
      intMask   <= '1;
      edgeSel   <= '0;
      polReg    <= '0;
      irqOut    <= '0;
      armed     <= 1'b0;
    end else begin
      pending   <= pendNext;
      inService <= isrNext;
      intMask   <= maskNext;
      irqOut    <= outNext;
      armed     <= 1'b1;
      if (stb.edgeWr) edgeSel <= cfgData;
      if (stb.polWr)  polReg  <= cfgData;
    end
  end

  for (genvar g = 0; g < NUM_IN; g++) begin : g_tab
    always_ff @(posedge clk) begin
      if (rst) begin
        vecTab[g]   <= '0;
        routeTab[g] <= '0;
      end else begin
        if (stb.vecWr && cfgIdx == IW'(g))   vecTab[g]   <= cfgData[VEC_W-1:0];
        if (stb.routeWr && cfgIdx == IW'(g)) routeTab[g] <= cfgData[VEC_W-1:0];
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (regsel_e'(rdSel))
      SEL_MASK:   rdData = intMask;
      SEL_EDGE:   rdData = edgeSel;
      SEL_STATUS: rdData = inService & ~intMask;
      SEL_POL:    rdData = polReg;
      SEL_VECTOR: rdData[VEC_W-1:0] = vecTab[rdIdx];
      SEL_ROUTE:  rdData[VEC_W-1:0] = routeTab[rdIdx];
      default:    rdData = '0;
    endcase
  end

  // R1: mask comes out of reset all ones
  a_r1_mask_ones: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&intMask));

  // R2: an edge bit's pending never drops unless cleared
  a_r2_edge_hold: assert property (@(posedge clk) disable iff (rst)
    armed |-> (($past(pending) & $past(edgeSel) & ~$past(clrBits) & ~pending) == '0));

  // R3: level bits track the sampled line
  a_r3_level_tracks: assert property (@(posedge clk) disable iff (rst)
    armed |-> (((pending ^ $past(irqIn)) & ~$past(edgeSel)) == '0));

  // R4: a raise pick is in service afterwards
  a_r4_rise_in_service: assert property (@(posedge clk) disable iff (rst)
    riseFound |=> inService[$past(riseIdx)]);

  // R5: a lower pick is out of service afterwards
  a_r5_fall_out_service: assert property (@(posedge clk) disable iff (rst)
    fallFound |=> !inService[$past(fallIdx)]);

  // R6: cleared edge bits leave service
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
    stb.clrWr |=> ((inService & $past(clrBits)) == '0));

  // R11: at most one lower and one raise per cycle on the outputs
  a_r11_out_delta: assert property (@(posedge clk) disable iff (rst)
    armed |-> ($countones(irqOut ^ $past(irqOut)) <= 2));
endmodule

// File: rtl/pic_dispatch_core.sv
module pic_dispatch_core
  import pic_pkg::*;
#(
  parameter int NUM_IN  = 64,
  parameter int NUM_OUT = 64,
  parameter int VEC_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_IN-1:0]         irqIn,
  input  logic                      cfgWrEn,
  input  logic [2:0]                cfgSel,
  input  logic [$clog2(NUM_IN)-1:0] cfgIdx,
  input  logic [NUM_IN-1:0]         cfgData,
  input  logic [2:0]                rdSel,
  input  logic [$clog2(NUM_IN)-1:0] rdIdx,
  output logic [NUM_IN-1:0]         rdData,
  output logic [NUM_OUT-1:0]        irqOut
);
  strobe_t           stb;
  logic [NUM_IN-1:0] riseEv, fallEv;

  pic_ctrl #(.NUM_IN(NUM_IN)) u_ctrl (
    .clk(clk), .rst(rst), .irqIn(irqIn), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .stb(stb), .riseEv(riseEv), .fallEv(fallEv)
  );

  pic_datapath #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .irqIn(irqIn), .riseEv(riseEv),
    .fallEv(fallEv), .cfgIdx(cfgIdx), .cfgData(cfgData), .rdSel(rdSel),
    .rdIdx(rdIdx), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/pic_dispatch_core_test.sv
module pic_dispatch_core_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] SM = 3'd0, SE = 3'd1, SC = 3'd2, SV = 3'd3,
                         SP = 3'd4, SR = 3'd5, SS = 3'd6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irqIn = '0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [5:0]  cfgIdx = '0;
  logic [63:0] cfgData = '0;
  logic [2:0]  rdSel = '0;
  logic [5:0]  rdIdx = '0;
  logic [63:0] rdData;
  logic [63:0] irqOut;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          isRead;
    logic [2:0]  sel;
    logic [5:0]  idx;
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  pic_dispatch_core uut (
    .clk(clk), .rst(rst), .irqIn(irqIn), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgIdx(cfgIdx), .cfgData(cfgData), .rdSel(rdSel), .rdIdx(rdIdx),
    .rdData(rdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [63:0] b(input int i);
    return 64'd1 << i;
  endfunction

  task automatic expOut(input string tag, input logic [63:0] v);
    item_t it;
    it.isRead = 1'b0; it.sel = '0; it.idx = '0; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic expRd(input string tag, input logic [2:0] s, input int i,
                       input logic [63:0] v);
    item_t it;
    it.isRead = 1'b1; it.sel = s; it.idx = i[5:0]; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor side of the scoreboard: pop and compare against the ports.
  task automatic drain();
    while (sb.size() > 0) begin
      item_t it;
      logic [63:0] got;
      it = sb.pop_front();
      if (it.isRead) begin
        rdSel = it.sel;
        rdIdx = it.idx;
        #1;
        got = rdData;
      end else begin
        got = irqOut;
      end
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
      end
    end
  endtask

  task automatic wr(input logic [2:0] s, input int i, input logic [63:0] d);
    cfgWrEn = 1'b1; cfgSel = s; cfgIdx = i[5:0]; cfgData = d;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0;
    drain();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expRd("R1 mask", SM, 0, '1);
    expRd("R1 edge", SE, 0, '0);
    expRd("R1 status", SS, 0, '0);
    expRd("R1 vector", SV, 3, '0);
    expOut("R1 outputs", '0);
    drain();

    // Configuration
    wr(SE, 0, b(3) | b(5) | b(9) | b(7)); tick();
    wr(SV, 3, 64'd10); tick();
    wr(SV, 5, 64'd20); tick();
    wr(SV, 7, 64'd10); tick();
    wr(SV, 9, 64'd70); tick();
    wr(SV, 12, 64'h1E); tick();
    wr(SP, 0, 64'hDEAD_BEEF_0123_4567); tick();
    wr(SR, 4, 64'h5A); tick();
    expRd("R12 vector readback", SV, 5, 64'd20);
    expRd("R9 polarity readback", SP, 0, 64'hDEAD_BEEF_0123_4567);
    expRd("R9 route readback", SR, 4, 64'h5A);
    expOut("R9 no dispatch from polarity/route", '0);
    drain();

    wr(SM, 0, '0);
    expOut("R7 unmask with nothing pending", '0);
    expRd("R8 mask read", SM, 0, '0);
    tick();

    // Two edge inputs rise together: lowest wins
    irqIn = b(3) | b(5);
    expOut("R4 lowest raised", b(10));
    expRd("R4 only one in service", SS, 0, b(3));
    tick();

    irqIn = '0;
    expOut("R2 falling edge keeps state", b(10));
    expRd("R2 status unchanged", SS, 0, b(3));
    tick();

    // Clear edge bit 3 and level bit 12 (no effect on 12)
    wr(SC, 0, b(3) | b(12));
    expOut("R6 clear lowers output", '0);
    expRd("R6 status after clear", SS, 0, '0);
    tick();

    // Level input
    irqIn = b(12);
    expOut("R3 level raise", b(30));
    expRd("R3 status", SS, 0, b(12));
    tick();

    wr(SC, 0, b(12));
    expOut("R6 clear ignores level bit", b(30));
    expRd("R6 level status kept", SS, 0, b(12));
    tick();

    wr(SM, 0, b(12));
    expOut("R7 mask of pending bit keeps output", b(30));
    expRd("R8 status masked", SS, 0, '0);
    tick();

    irqIn = '0;
    expOut("R5 level fall lowers", '0);
    tick();

    wr(SM, 0, '0);
    expRd("R5 level out of service", SS, 0, '0);
    tick();

    // Bit 5 stayed pending since the double rise
    wr(SM, 0, b(5)); tick();
    wr(SM, 0, '0);
    expOut("R7 unmask raises held pending", b(20));
    expRd("R2 held pending served", SS, 0, b(5));
    tick();

    irqIn = b(9);
    expOut("R10 vector 70 drives nothing", b(20));
    expRd("R10 still in service", SS, 0, b(5) | b(9));
    tick();
    irqIn = '0; tick();

    wr(SC, 0, b(5) | b(9));
    expOut("R6 clear two bits", '0);
    expRd("R6 both out of service", SS, 0, '0);
    tick();

    irqIn = b(3);
    expOut("R4 raise on 3", b(10));
    tick();
    irqIn = '0; tick();

    // Lower of 3 and raise of 7 on the same output in one cycle
    wr(SC, 0, b(3));
    irqIn = b(7);
    expOut("R11 raise wins over lower", b(10));
    expRd("R11 status", SS, 0, b(7));
    tick();

    irqIn = '0; tick();
    wr(SE, 0, b(3) | b(5) | b(9)); tick();
    expOut("R3 mode change idle", b(10));
    tick();
    wr(SM, 0, b(7));
    expOut("R7 newly masked lowers", '0);
    tick();
    wr(SM, 0, '0);
    expOut("R7 unmask without pending", '0);
    expRd("R7 bit 7 left service", SS, 0, '0);
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule